// File: doc/BRIEF.md
# Branch Target Buffer Predictor

This block predicts the next fetch address of an instruction fetch stage. Each cycle the fetch unit presents its current fetch address. The block looks it up in a direct-mapped table of branch records. Each record holds a tag, a branch target and a two-bit saturating history. When the lookup hits and the history leans toward taken, the block offers the stored target as the next fetch address. In every other case it offers the sequential address. The lookup is purely combinational, so the answer is available in the same cycle as the address.

Resolved branches come back on an update port with their real outcome and target, and the table is written on the next clock edge. A branch that is already present has its history moved one step toward the outcome. A branch that is absent is recorded only when it was taken. It goes into its slot with the strongly-not-taken history and replaces whatever record was there. A branch that is absent and not taken leaves the table unchanged. A global enable input masks every prediction without stopping the learning.

Top module: `btb_predictor`

## Requirements
- R1: After reset every slot is empty, so every lookup reports a miss until some update with a taken outcome has been applied.
- R2: The slot index is fetch address bits [8:2]. The tag is every other address bit: bits [31:9] followed by bits [1:0]. A lookup hits only when the slot holds a record and its tag equals the tag of the address.
- R3: History encoding is 2'b00 strongly not taken, 2'b01 weakly not taken, 2'b10 weakly taken and 2'b11 strongly taken. On a hit whose history is 2'b10 or 2'b11, pred_taken_o is 1 and pred_next_pc_o is the stored target.
- R4: On a miss, or on a hit whose history is 2'b00 or 2'b01, pred_taken_o is 0 and pred_next_pc_o equals fetch_pc_i + 4.
- R5: An update that misses and has upd_taken_i = 1 writes the branch, with tag, target and history 2'b00, so the next lookup of that address hits but predicts not taken.
- R6: An update that misses and has upd_taken_i = 0 changes no slot. A later lookup of that address still misses.
- R7: An update that hits moves the history one step toward the outcome and saturates at 2'b11 and at 2'b00.
- R8: An allocation overwrites the slot's previous record, so the old branch that shared the index then misses.
- R9: With enable_i = 0 every lookup reports a miss with the sequential next address. Updates are still applied to the table.
- R10: A lookup made in the same cycle as an update to the same slot returns the contents from before that update.
- R11: An update that hits leaves the stored target unchanged, even when upd_target_i differs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Prediction enable |
| fetch_pc_i | input | 32 | Current fetch address to look up |
| pred_hit_o | output | 1 | Lookup found a matching record |
| pred_taken_o | output | 1 | Prediction is taken |
| pred_next_pc_o | output | 32 | Predicted next fetch address |
| upd_valid_i | input | 1 | A resolved branch is presented this cycle |
| upd_pc_i | input | 32 | Address of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome of the resolved branch |
| upd_target_i | input | 32 | Actual target of the resolved branch |

## Verification
The assertions check on every cycle that a disabled lookup always misses and falls through, and that a not-taken prediction always gives the sequential address. They also check that no hit appears before the first taken update, and that a branch just updated as taken hits on the next cycle. Other behaviours depend on the history a slot has built up: the saturating steps, the strongly-not-taken start state, the target kept on a hit, aliasing eviction and the pre-update read. The bench's scenarios show these by comparing against a shadow table that it updates itself.

// File: rtl/btb_pkg.sv
package btb_pkg;

    typedef enum logic [1:0] {
        HIST_SNT = 2'b00,
        HIST_WNT = 2'b01,
        HIST_WT  = 2'b10,
        HIST_ST  = 2'b11
    } hist_e;

    function automatic hist_e hist_step(hist_e cur, logic taken);
        hist_e nxt;
        unique case (cur)
            HIST_SNT: nxt = taken ? HIST_WNT : HIST_SNT;
            HIST_WNT: nxt = taken ? HIST_WT  : HIST_SNT;
            HIST_WT:  nxt = taken ? HIST_ST  : HIST_WNT;
            default:  nxt = taken ? HIST_ST  : HIST_WT;
        endcase
        return nxt;
    endfunction

    function automatic logic hist_says_taken(hist_e h);
        return h == HIST_WT || h == HIST_ST;
    endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 7,
    parameter int IDX_LSB = 2,
    localparam int TAG_W  = ADDR_W - IDX_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic [IDX_W-1:0]  idx_o,
    output logic [TAG_W-1:0]  tag_o
);
    assign idx_o = addr_i[IDX_LSB +: IDX_W];

    generate
        if (IDX_LSB > 0) begin : g_low
            assign tag_o = {addr_i[ADDR_W-1:IDX_LSB+IDX_W], addr_i[IDX_LSB-1:0]};
        end else begin : g_nolow
            assign tag_o = addr_i[ADDR_W-1:IDX_W];
        end
    endgenerate
endmodule

// File: rtl/btb_store.sv
module btb_store
    import btb_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int IDX_W   = 7,
    localparam int TAG_W   = ADDR_W - IDX_W,
    localparam int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    // read port A: fetch lookup
    input  logic [IDX_W-1:0]  a_idx_i,
    output logic              a_valid_o,
    output logic [TAG_W-1:0]  a_tag_o,
    output logic [ADDR_W-1:0] a_tgt_o,
    output hist_e             a_hist_o,
    // read port B: update inspection
    input  logic [IDX_W-1:0]  b_idx_i,
    output logic              b_valid_o,
    output logic [TAG_W-1:0]  b_tag_o,
    output logic [ADDR_W-1:0] b_tgt_o,
    output hist_e             b_hist_o,
    // write port
    input  logic              we_i,
    input  logic [IDX_W-1:0]  w_idx_i,
    input  logic [TAG_W-1:0]  w_tag_i,
    input  logic [ADDR_W-1:0] w_tgt_i,
    input  hist_e             w_hist_i
);
    logic [ENTRIES-1:0] valid_d, valid_q;
    logic [TAG_W-1:0]   tag_q  [ENTRIES];
    logic [ADDR_W-1:0]  tgt_q  [ENTRIES];
    hist_e              hist_q [ENTRIES];

    always_comb begin
        valid_d = valid_q;
        if (we_i) valid_d[w_idx_i] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) valid_q <= '0;
        else        valid_q <= valid_d;
    end

    always_ff @(posedge clk) begin
        if (we_i) begin
            tag_q[w_idx_i]  <= w_tag_i;
            tgt_q[w_idx_i]  <= w_tgt_i;
            hist_q[w_idx_i] <= w_hist_i;
        end
    end

    assign a_valid_o = valid_q[a_idx_i];
    assign a_tag_o   = tag_q[a_idx_i];
    assign a_tgt_o   = tgt_q[a_idx_i];
    assign a_hist_o  = hist_q[a_idx_i];

    assign b_valid_o = valid_q[b_idx_i];
    assign b_tag_o   = tag_q[b_idx_i];
    assign b_tgt_o   = tgt_q[b_idx_i];
    assign b_hist_o  = hist_q[b_idx_i];
endmodule

// File: rtl/btb_update_ctl.sv
module btb_update_ctl
    import btb_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 7,
    localparam int TAG_W = ADDR_W - IDX_W
) (
    input  logic              upd_valid_i,
    input  logic              upd_taken_i,
    input  logic [TAG_W-1:0]  upd_tag_i,
    input  logic [ADDR_W-1:0] upd_target_i,
    input  logic              slot_valid_i,
    input  logic [TAG_W-1:0]  slot_tag_i,
    input  logic [ADDR_W-1:0] slot_tgt_i,
    input  hist_e             slot_hist_i,
    output logic              we_o,
    output logic [TAG_W-1:0]  w_tag_o,
    output logic [ADDR_W-1:0] w_tgt_o,
    output hist_e             w_hist_o
);
    typedef struct packed {
        logic              we;
        logic [TAG_W-1:0]  tag;
        logic [ADDR_W-1:0] tgt;
        hist_e             hist;
    } wr_req_t;

    wr_req_t req_d;
    logic    slot_hit;

    always_comb begin
        slot_hit   = slot_valid_i && (slot_tag_i == upd_tag_i);
        req_d.we   = 1'b0;
        req_d.tag  = slot_tag_i;
        req_d.tgt  = slot_tgt_i;
        req_d.hist = slot_hist_i;
        if (upd_valid_i) begin
            if (slot_hit) begin
                req_d.we   = 1'b1;
                req_d.hist = hist_step(slot_hist_i, upd_taken_i);
            end else if (upd_taken_i) begin
                req_d.we   = 1'b1;
                req_d.tag  = upd_tag_i;
                req_d.tgt  = upd_target_i;
                req_d.hist = HIST_SNT;
            end
        end
    end

    assign we_o     = req_d.we;
    assign w_tag_o  = req_d.tag;
    assign w_tgt_o  = req_d.tgt;
    assign w_hist_o = req_d.hist;
endmodule

// File: rtl/btb_predictor.sv
module btb_predictor
    import btb_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int IDX_W       = 7,
    parameter int IDX_LSB     = 2,
    parameter int INSTR_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable_i,
    input  logic [ADDR_W-1:0] fetch_pc_i,
    output logic              pred_hit_o,
    output logic              pred_taken_o,
    output logic [ADDR_W-1:0] pred_next_pc_o,
    input  logic              upd_valid_i,
    input  logic [ADDR_W-1:0] upd_pc_i,
    input  logic              upd_taken_i,
    input  logic [ADDR_W-1:0] upd_target_i
);
    localparam int TAG_W = ADDR_W - IDX_W;
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    typedef struct packed {
        logic              hit;
        logic              taken;
        logic [ADDR_W-1:0] next_pc;
    } lookup_t;

    logic [IDX_W-1:0]  lk_idx, up_idx;
    logic [TAG_W-1:0]  lk_tag, up_tag;
    logic              a_valid, b_valid;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [ADDR_W-1:0] a_tgt, b_tgt;
    hist_e             a_hist, b_hist;
    logic              we;
    logic [TAG_W-1:0]  w_tag;
    logic [ADDR_W-1:0] w_tgt;
    hist_e             w_hist;
    lookup_t           lk_d;

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_split_lk (
        .addr_i(fetch_pc_i), .idx_o(lk_idx), .tag_o(lk_tag)
    );

    btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB)) u_split_up (
        .addr_i(upd_pc_i), .idx_o(up_idx), .tag_o(up_tag)
    );

    btb_store #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .a_idx_i(lk_idx), .a_valid_o(a_valid), .a_tag_o(a_tag), .a_tgt_o(a_tgt), .a_hist_o(a_hist),
        .b_idx_i(up_idx), .b_valid_o(b_valid), .b_tag_o(b_tag), .b_tgt_o(b_tgt), .b_hist_o(b_hist),
        .we_i(we), .w_idx_i(up_idx), .w_tag_i(w_tag), .w_tgt_i(w_tgt), .w_hist_i(w_hist)
    );

    btb_update_ctl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctl (
        .upd_valid_i(upd_valid_i), .upd_taken_i(upd_taken_i),
        .upd_tag_i(up_tag), .upd_target_i(upd_target_i),
        .slot_valid_i(b_valid), .slot_tag_i(b_tag), .slot_tgt_i(b_tgt), .slot_hist_i(b_hist),
        .we_o(we), .w_tag_o(w_tag), .w_tgt_o(w_tgt), .w_hist_o(w_hist)
    );

    always_comb begin
        lk_d.hit     = enable_i && a_valid && (a_tag == lk_tag);
        lk_d.taken   = lk_d.hit && hist_says_taken(a_hist);
        lk_d.next_pc = lk_d.taken ? a_tgt : (fetch_pc_i + STEP);
    end

    assign pred_hit_o     = lk_d.hit;
    assign pred_taken_o   = lk_d.taken;
    assign pred_next_pc_o = lk_d.next_pc;
endmodule

// File: rtl/btb_predictor_chk.sv
module btb_predictor_chk #(
    parameter int ADDR_W      = 32,
    parameter int INSTR_BYTES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              enable_i,
    input logic [ADDR_W-1:0] fetch_pc_i,
    input logic              pred_hit_o,
    input logic              pred_taken_o,
    input logic [ADDR_W-1:0] pred_next_pc_o,
    input logic              upd_valid_i,
    input logic [ADDR_W-1:0] upd_pc_i,
    input logic              upd_taken_i
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(INSTR_BYTES);

    logic              seen_alloc_q;
    logic              prev_tk_q;
    logic [ADDR_W-1:0] prev_pc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_alloc_q <= 1'b0;
            prev_tk_q    <= 1'b0;
            prev_pc_q    <= '0;
        end else begin
            if (upd_valid_i && upd_taken_i) seen_alloc_q <= 1'b1;
            prev_tk_q <= upd_valid_i && upd_taken_i;
            prev_pc_q <= upd_pc_i;
        end
    end

    // R1
    p_empty_miss_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_alloc_q |-> !pred_hit_o);

    // R3
    p_taken_needs_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pred_taken_o |-> pred_hit_o);

    // R4
    p_seq_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_taken_o |-> pred_next_pc_o == fetch_pc_i + STEP);

    // R9
    p_disabled_miss_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |-> !pred_hit_o && !pred_taken_o);

    // R5
    p_alloc_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_tk_q && enable_i && fetch_pc_i == prev_pc_q) |-> pred_hit_o);
endmodule

bind btb_predictor btb_predictor_chk #(.ADDR_W(ADDR_W), .INSTR_BYTES(INSTR_BYTES)) u_chk (
    .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .fetch_pc_i(fetch_pc_i),
    .pred_hit_o(pred_hit_o), .pred_taken_o(pred_taken_o), .pred_next_pc_o(pred_next_pc_o),
    .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i)
);

// File: tb/tb_btb_predictor.sv
`timescale 1ns/1ps
module tb_btb_predictor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b1;
    logic [31:0] fetch_pc_i = '0;
    logic        pred_hit_o, pred_taken_o;
    logic [31:0] pred_next_pc_o;
    logic        upd_valid_i = 1'b0;
    logic [31:0] upd_pc_i = '0;
    logic        upd_taken_i = 1'b0;
    logic [31:0] upd_target_i = '0;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    btb_predictor dut (
        .clk(clk), .rst_n(rst_n), .enable_i(enable_i), .fetch_pc_i(fetch_pc_i),
        .pred_hit_o(pred_hit_o), .pred_taken_o(pred_taken_o), .pred_next_pc_o(pred_next_pc_o),
        .upd_valid_i(upd_valid_i), .upd_pc_i(upd_pc_i), .upd_taken_i(upd_taken_i),
        .upd_target_i(upd_target_i)
    );

    // shadow table built from the requirements
    bit          mv   [128];
    logic [24:0] mtag [128];
    logic [31:0] mtgt [128];
    logic [1:0]  mh   [128];

    function automatic logic [6:0]  f_idx(logic [31:0] a); return a[8:2]; endfunction
    function automatic logic [24:0] f_tag(logic [31:0] a); return {a[31:9], a[1:0]}; endfunction
    function automatic logic [1:0] f_step(logic [1:0] h, logic t);
        if (t) return (h == 2'b11) ? 2'b11 : h + 2'b01;
        return (h == 2'b00) ? 2'b00 : h - 2'b01;
    endfunction

    task automatic check(string req, logic eh, logic et, logic [31:0] en);
        total++;
        if (pred_hit_o !== eh || pred_taken_o !== et || pred_next_pc_o !== en) begin
            bad++;
            $display("FAIL %s pc=%h actual hit=%b tk=%b next=%h expected hit=%b tk=%b next=%h",
                     req, fetch_pc_i, pred_hit_o, pred_taken_o, pred_next_pc_o, eh, et, en);
        end
    endtask

    // drive one cycle, check the combinational lookup, then advance the shadow table
    task automatic step(string req, logic [31:0] fpc, logic en, logic uv,
                        logic [31:0] upc, logic ut, logic [31:0] utgt);
        logic [6:0] i;
        logic eh, et;
        @(negedge clk);
        fetch_pc_i = fpc; enable_i = en;
        upd_valid_i = uv; upd_pc_i = upc; upd_taken_i = ut; upd_target_i = utgt;
        #1;
        i  = f_idx(fpc);
        eh = en && mv[i] && mtag[i] == f_tag(fpc);
        et = eh && mh[i][1];
        check(req, eh, et, et ? mtgt[i] : fpc + 32'd4);
        if (uv) begin
            i = f_idx(upc);
            if (mv[i] && mtag[i] == f_tag(upc)) mh[i] = f_step(mh[i], ut);
            else if (ut) begin
                mv[i] = 1'b1; mtag[i] = f_tag(upc); mtgt[i] = utgt; mh[i] = 2'b00;
            end
        end
    endtask

    task automatic look(string req, logic [31:0] fpc, logic en);
        step(req, fpc, en, 1'b0, 32'h0, 1'b0, 32'h0);
    endtask

    task automatic upd(string req, logic [31:0] fpc, logic [31:0] upc, logic ut, logic [31:0] t);
        step(req, fpc, 1'b1, 1'b1, upc, ut, t);
    endtask

    localparam logic [31:0] A  = 32'h0000_1010;
    localparam logic [31:0] B  = 32'h0000_1210;  // same slot as A, other tag
    localparam logic [31:0] T1 = 32'h0000_8000;
    localparam logic [31:0] T2 = 32'h0000_9000;

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] pool [12];
        void'($urandom(32'd1234));
        for (int k = 0; k < 128; k++) mv[k] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        look("R1", A, 1'b1);
        look("R1", 32'h0000_0000, 1'b1);
        upd ("R6", A, A, 1'b0, T1);          // miss, not taken: no write
        look("R6", A, 1'b1);
        upd ("R10", A, A, 1'b1, T1);         // allocate; same-cycle lookup misses
        look("R5", A, 1'b1);                 // SNT: hit, sequential
        upd ("R10", A, A, 1'b1, T1);         // lookup sees SNT while step to WNT
        look("R7", A, 1'b1);                 // WNT
        upd ("R7", A, A, 1'b1, T1);          // -> WT
        look("R3", A, 1'b1);                 // predicts T1
        upd ("R11", A, A, 1'b1, T2);         // -> ST, target stays T1
        look("R11", A, 1'b1);
        upd ("R7", A, A, 1'b1, T1);          // saturate at ST
        upd ("R7", A, A, 1'b0, T1);          // -> WT
        look("R7", A, 1'b1);
        upd ("R7", A, A, 1'b0, T1);          // -> WNT
        look("R4", A, 1'b1);
        upd ("R7", A, A, 1'b0, T1);          // -> SNT
        upd ("R7", A, A, 1'b0, T1);          // saturate at SNT
        look("R7", A, 1'b1);
        look("R2", A ^ 32'h1, 1'b1);         // low bits differ: miss
        look("R2", A ^ 32'h4000_0000, 1'b1); // upper tag differs: miss
        upd ("R8", A, B, 1'b1, T2);          // evicts A
        look("R8", A, 1'b1);
        look("R8", B, 1'b1);
        step("R9", B, 1'b0, 1'b1, B, 1'b1, T2);  // disabled, still learns
        step("R9", B, 1'b0, 1'b1, B, 1'b1, T2);
        look("R9", B, 1'b0);
        look("R9", B, 1'b1);                 // now WT: predicts T2

        for (int k = 0; k < 12; k++) begin
            logic [31:0] r;
            r = $urandom;
            pool[k] = {r[31:9], 7'(4 + (k % 3) * 5), 2'b00};
        end
        for (int n = 0; n < 4000; n++) begin
            logic [31:0] fp, up;
            fp = pool[$urandom % 12];
            up = pool[$urandom % 12];
            if (($urandom % 8) == 0) fp = $urandom;
            step("R2/R3/R4/R7/R10", fp, ($urandom % 10) != 0, ($urandom % 10) < 6,
                 up, ($urandom % 10) < 6, $urandom);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule